// File: doc/BRIEF.md
# Four-Channel Double-Buffered Converter Register Front End

This block is the digital register front end of a four-channel, 12-bit digital-to-analog converter. Each channel has two register stages in series. The first stage is a staging register that the host writes over a shared data bus. The second stage is an output register that drives the converter code. The host picks one channel with a 2-bit address and writes its staging register with an active-low select and an active-low write strobe.

The bus can be used in two ways. In wide mode all twelve bits arrive in one access. In narrow mode two accesses are made on the top eight data lines. One access, with the part select high, fills the upper eight bits. The other access, with the part select low, fills the lower four bits; those four bits are taken from the four most significant data lines through a multiplexer.

A second, fully separate pair of active-low strobes copies all four staging registers into the output registers at once. The four converters can therefore be loaded one at a time and then updated together. Latch-style transparency is modelled here as clocked registers with enables.

Top module: `quad_dac_frontend`

## Requirements
- R1: While `rst_n` is low, all staging and output registers are cleared, so `dac_out` reads zero.
- R2: A staging write happens on a rising clock edge where `cs_n` and `wr_n` are both low. The address selects the channel: 0 is A, 1 is B, 2 is C and 3 is D. Channel k appears on `dac_out[12k+11:12k]`. Only the addressed channel's staging register changes.
- R3: With `wide_bus` high, a write loads all 12 bits of the addressed staging register from `data[11:0]`, and `part_hi` has no effect.
- R4: With `wide_bus` low and `part_hi` high, a write loads staging bits 11:4 from `data[11:4]`. Staging bits 3:0 keep their value.
- R5: With `wide_bus` low and `part_hi` low, a write loads staging bits 3:0 from `data[11:8]`. Staging bits 11:4 keep their value.
- R6: A staging write leaves `dac_out` unchanged until a transfer occurs.
- R7: On a rising edge where `xfer_n` and `xwr_n` are both low, all four output registers load their staging values together. The new values are visible on `dac_out` after that edge.
- R8: When a staging write and a transfer fall on the same edge, the output register takes the staging value held before that write.
- R9: If `cs_n` or `wr_n` is high, no staging register changes. If `xfer_n` or `xwr_n` is high, `dac_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select for staging writes |
| wr_n | input | 1 | Active-low staging write strobe |
| addr | input | 2 | Channel address (0=A … 3=D) |
| wide_bus | input | 1 | 1: 12-bit access; 0: narrow (byte/nibble) access |
| part_hi | input | 1 | Narrow mode: 1 loads upper 8 bits, 0 loads lower 4 bits |
| data | input | 12 | Data bus |
| xfer_n | input | 1 | Active-low transfer enable |
| xwr_n | input | 1 | Active-low transfer strobe |
| dac_out | output | 48 | Output register codes, channel k at bits 12k+11:12k |

## Verification
A staging write and a transfer can fall on the same clock edge. In that case the output register must take the old staging value, and the staging register must take the new bus value.

The bench provokes this in two ways:
- in a directed case, by writing a channel with a different value while a transfer is asserted;
- through random stimulus, which often asserts both strobe pairs at once.

A bench model updates its output copy from its staging copy before it applies the write. Every cycle, `dac_out` is compared with that model. A later transfer then exposes the new staging value, which confirms that the write was not lost.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  typedef enum logic [1:0] {
    WK_FULL = 2'd0,
    WK_HIGH = 2'd1,
    WK_LOW  = 2'd2
  } wr_kind_t;

  function automatic wr_kind_t classify(input logic wide, input logic hi);
    if (wide) return WK_FULL;
    return hi ? WK_HIGH : WK_LOW;
  endfunction
endpackage

// File: rtl/qdac_decode.sv
module qdac_decode #(
  parameter int NCH = 4,
  localparam int AW = $clog2(NCH)
) (
  input  logic           en,
  input  logic [AW-1:0]  addr,
  output logic [NCH-1:0] sel
);
  always_comb begin
    sel = '0;
    for (int k = 0; k < NCH; k++)
      if (en && addr == AW'(k)) sel[k] = 1'b1;
  end
endmodule

// File: rtl/qdac_chan.sv
module qdac_chan
  import qdac_pkg::*;
#(
  parameter int DW   = 12,
  parameter int HI_W = 8,
  localparam int LO_W = DW - HI_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  wr_kind_t      kind,
  input  logic [DW-1:0] data,
  input  logic          xfer,
  output logic [DW-1:0] dac_q
);
  logic [DW-1:0] in_q;
  logic [DW-1:0] in_next;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                          input logic [DW-1:0] d,
                                          input wr_kind_t k);
    case (k)
      WK_HIGH: return {d[DW-1 -: HI_W], old[LO_W-1:0]};
      WK_LOW:  return {old[DW-1 -: HI_W], d[DW-1 -: LO_W]};
      default: return d;
    endcase
  endfunction

  assign in_next = merge(in_q, data, kind);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     in_q <= '0;
    else if (wr_en) in_q <= in_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dac_q <= '0;
    else if (xfer) dac_q <= in_q;
  end

  // R4: an upper-part write keeps the low nibble
  a_r4_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && kind == WK_HIGH |=> in_q[LO_W-1:0] == $past(in_q[LO_W-1:0]));
  // R5: a nibble write keeps the upper byte
  a_r5_high_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && kind == WK_LOW |=> in_q[DW-1 -: HI_W] == $past(in_q[DW-1 -: HI_W]));
  // R6: the output changes only on a transfer
  a_r6_dac_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(dac_q));
  // R9: the staging register holds without a write
  a_r9_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(in_q));
  // R8: a transfer takes the pre-write staging value
  a_r8_old_value: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && wr_en |=> dac_q == $past(in_q));
endmodule

// File: rtl/quad_dac_frontend.sv
module quad_dac_frontend
  import qdac_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int DW   = 12,
  parameter int HI_W = 8,
  localparam int AW  = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [AW-1:0]     addr,
  input  logic              wide_bus,
  input  logic              part_hi,
  input  logic [DW-1:0]     data,
  input  logic              xfer_n,
  input  logic              xwr_n,
  output logic [NCH*DW-1:0] dac_out
);
  wire       wr_strobe = !cs_n && !wr_n;
  wire       xfer_go   = !xfer_n && !xwr_n;
  wr_kind_t  kind;
  logic [NCH-1:0] chan_wr;

  assign kind = classify(wide_bus, part_hi);

  qdac_decode #(.NCH(NCH)) dec_i (
    .en(wr_strobe), .addr(addr), .sel(chan_wr)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_chan
    qdac_chan #(.DW(DW), .HI_W(HI_W)) chan_i (
      .clk(clk), .rst_n(rst_n), .wr_en(chan_wr[k]), .kind(kind),
      .data(data), .xfer(xfer_go), .dac_q(dac_out[k*DW +: DW])
    );
  end

  // R2: at most one channel enabled per write
  a_r2_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_wr));
  // R2: a write strobe always reaches exactly one channel
  a_r2_strobe_hits: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> $countones(chan_wr) == 1);
  // R9: without a strobe, no channel is enabled
  a_r9_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe |-> chan_wr == '0);
  // R7: without a transfer, all outputs hold
  a_r7_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_go |=> $stable(dac_out));
endmodule

// File: tb/quad_dac_frontend_tb.sv
module quad_dac_frontend_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, wr_n = 1'b1, xfer_n = 1'b1, xwr_n = 1'b1;
  logic [1:0]  addr = '0;
  logic        wide_bus = 1'b1, part_hi = 1'b1;
  logic [11:0] data = '0;
  logic [47:0] dac_out;

  logic [11:0] stg_m [4];
  logic [11:0] dac_m [4];
  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  quad_dac_frontend dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
    .wide_bus(wide_bus), .part_hi(part_hi), .data(data),
    .xfer_n(xfer_n), .xwr_n(xwr_n), .dac_out(dac_out)
  );

  function automatic logic [11:0] expect_stage(logic [11:0] old, logic [11:0] d,
                                               logic wide, logic hi);
    logic [11:0] mask, val;
    if (wide) begin mask = 12'hFFF; val = d; end
    else if (hi) begin mask = 12'hFF0; val = d & 12'hFF0; end
    else begin mask = 12'h00F; val = {8'h00, d[11:8]}; end
    return (old & ~mask) | val;
  endfunction

  function automatic logic [47:0] packed_model();
    return {dac_m[3], dac_m[2], dac_m[1], dac_m[0]};
  endfunction

  task automatic check(string req, logic [47:0] got, logic [47:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // one edge; model updates transfer before write (R8)
  task automatic step(string req);
    @(posedge clk);
    if (!xfer_n && !xwr_n) for (int k = 0; k < 4; k++) dac_m[k] = stg_m[k];
    if (!cs_n && !wr_n) stg_m[addr] = expect_stage(stg_m[addr], data, wide_bus, part_hi);
    @(negedge clk);
    check(req, dac_out, packed_model());
    cs_n = 1; wr_n = 1; xfer_n = 1; xwr_n = 1;
  endtask

  task automatic wr(logic [1:0] a, logic [11:0] d, logic wide, logic hi, string req);
    addr = a; data = d; wide_bus = wide; part_hi = hi; cs_n = 0; wr_n = 0;
    step(req);
  endtask

  task automatic xfer(string req);
    xfer_n = 0; xwr_n = 0;
    step(req);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog got=%0d exp=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 4; k++) begin stg_m[k] = 0; dac_m[k] = 0; end
    repeat (3) @(negedge clk);
    check("R1", dac_out, 48'h0);
    rst_n = 1;
    @(negedge clk);

    // R2 / R6: each address hits only its own channel; no output change
    for (int k = 0; k < 4; k++) wr(2'(k), 12'h111 * 12'(k + 1), 1, 1, "R6");
    xfer("R7");
    check("R2", dac_out, {12'h444, 12'h333, 12'h222, 12'h111});
    // R3: part_hi has no effect in wide mode
    wr(2'd1, 12'hABC, 1, 0, "R3");
    xfer("R3");
    check("R3", dac_out[23:12], 48'(12'hABC));
    // R4: upper byte only
    wr(2'd2, 12'h5A7, 0, 1, "R4");
    xfer("R4");
    check("R4", 48'(dac_out[35:24]), 48'(12'h5A3));
    // R5: nibble from top data lines
    wr(2'd2, 12'hC00, 0, 0, "R5");
    xfer("R5");
    check("R5", 48'(dac_out[35:24]), 48'(12'h5AC));
    // R9: select high blocks the write
    addr = 0; data = 12'hFFF; wide_bus = 1; cs_n = 1; wr_n = 0; step("R9");
    addr = 0; data = 12'hFFF; wide_bus = 1; cs_n = 0; wr_n = 1; step("R9");
    xfer("R9");
    check("R9", 48'(dac_out[11:0]), 48'(12'h111));
    // R9: half a transfer strobe does nothing
    wr(2'd3, 12'h777, 1, 1, "R6");
    xfer_n = 0; step("R9");
    check("R9", 48'(dac_out[47:36]), 48'(12'h444));
    // R8: simultaneous write and transfer
    addr = 3; data = 12'h999; wide_bus = 1; cs_n = 0; wr_n = 0; xfer_n = 0; xwr_n = 0;
    step("R8");
    check("R8", 48'(dac_out[47:36]), 48'(12'h777));
    xfer("R8");
    check("R8", 48'(dac_out[47:36]), 48'(12'h999));

    // random mix
    for (int i = 0; i < 2000; i++) begin
      addr = 2'($urandom); data = 12'($urandom);
      wide_bus = 1'($urandom); part_hi = 1'($urandom);
      cs_n = ($urandom % 4) == 0; wr_n = ($urandom % 4) == 0;
      xfer_n = ($urandom % 3) != 0; xwr_n = ($urandom % 3) != 0;
      step("R7");
    end

    // R1: reset mid-run clears everything
    rst_n = 0;
    for (int k = 0; k < 4; k++) begin stg_m[k] = 0; dac_m[k] = 0; end
    @(negedge clk);
    check("R1", dac_out, 48'h0);
    rst_n = 1;
    @(negedge clk);
    xfer("R1");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule